// File: doc/BRIEF.md
# Product Register Combine and Rounding Unit

This block holds a multiply result split across four word-sized parts: a low word, a middle word, a second middle word and a high word. Combinationally, it merges the parts into one signed value of width `2*WORD_W + HI_W` (40 bits by default). The two middle words are summed before they are placed, so the sum may carry into the bit just above them. Only the lowest `HI_W` bits of the high word count, and they are taken as signed. The merged value is also offered rounded to a multiple of `2^WORD_W`, using round-half-to-even.

A whole value can be loaded in one cycle. It is split into low and middle, the second middle word is cleared, and the top bits go into the high word with zeros above them. Each part can also be written word by word. A separate rounder applies the same rounding rule to an accumulator value supplied on an input.

The house style asks for a state machine. The block has no sequencing, so it has no state machine. It has one register per part, and each register updates on the clock edge.

Top module: `prod_round_unit`

## Requirements
- R1: While reset is asserted, and at the first clock after it is released, all four parts read zero. The product and both rounded outputs then read zero too (for `acc_in` of zero).
- R2: `wr_en` bit 0 selects the low word, bit 1 the middle word, bit 2 the second middle word and bit 3 the high word. A set bit loads `wr_data` into that part at the next rising edge. Parts whose bit is clear keep their value.
- R3: `load_en` stores `load_val[WORD_W-1:0]` into low and `load_val[2*WORD_W-1:WORD_W]` into middle at the next edge. It clears the second middle word. It places `load_val[ACC_W-1:2*WORD_W]` in the high word's bottom `HI_W` bits, with zeros above.
- R4: When `load_en` and any `wr_en` bit are set in the same cycle, the load alone decides the new contents of every part.
- R5: `prod_out` equals the high byte sign-extended and multiplied by `2^(2*WORD_W)`, plus ((middle + middle2) × `2^WORD_W` OR low), taken modulo `2^ACC_W`. After a load, `prod_out` equals the loaded value.
- R6: High-word bits at and above `HI_W` have no effect on `prod_out` or `prod_rnd`.
- R7: `prod_rnd` rounds `prod_out` as follows. If bit `WORD_W` is 1, it adds `2^(WORD_W-1)`; otherwise it adds `2^(WORD_W-1)-1`. It then clears bits `WORD_W-1:0`.
- R8: `acc_rnd` applies the R7 rule to `acc_in` in the same cycle, with no clock involved.
- R9: A carry past bit `ACC_W-1` in the middle-word sum, the high-byte add or the rounding add is dropped, so the outputs wrap modulo `2^ACC_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 4 | Per-part write enables (bit order in R2) |
| wr_data | input | WORD_W | Data for word writes |
| load_en | input | 1 | Full-value load strobe |
| load_val | input | ACC_W | Value for a full load |
| acc_in | input | ACC_W | Accumulator value to round |
| parts_q | output | 4*WORD_W | Part contents: low, middle, middle2 and high, from the least significant word up |
| prod_out | output | ACC_W | Merged signed product |
| prod_rnd | output | ACC_W | Rounded product |
| acc_rnd | output | ACC_W | Rounded accumulator |

## Verification
The bench builds the block with `WORD_W=4` and `HI_W=2`, which gives 10-bit values. At that size, every combination of the four 4-bit parts can be written and checked. That sweep includes every middle-sum carry, every sign of the high byte, and every value of the ignored high-word bits. Every 10-bit load value, both alone and against conflicting word writes, and every accumulator value can also be applied. Every tie and wrap case of the rounding is therefore covered, rather than sampled.

// File: rtl/prod_round_pkg.sv
package prod_round_pkg;

    localparam int NUM_PARTS = 4;

    // Position of each part in the register; wr_en bits and parts_q words follow it.
    typedef enum logic [1:0] {
        PART_LOW  = 2'd0,
        PART_MID  = 2'd1,
        PART_MID2 = 2'd2,
        PART_HIGH = 2'd3
    } part_e;

endpackage

// File: rtl/prod_part_regs.sv
module prod_part_regs
    import prod_round_pkg::*;
#(
    parameter  int WORD_W  = 16,
    parameter  int HI_W    = 8,
    localparam int ACC_W   = 2*WORD_W + HI_W,
    localparam int PARTS_W = NUM_PARTS*WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PARTS-1:0] wr_en,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 load_en,
    input  logic [ACC_W-1:0]     load_val,
    output logic [PARTS_W-1:0]   parts_q
);

    logic [WORD_W-1:0] load_word [NUM_PARTS];

    // Split of a full value into the four parts.
    always_comb begin
        load_word[int'(PART_LOW)]  = load_val[WORD_W-1:0];
        load_word[int'(PART_MID)]  = load_val[2*WORD_W-1:WORD_W];
        load_word[int'(PART_MID2)] = '0;
        load_word[int'(PART_HIGH)] = WORD_W'(load_val[ACC_W-1:2*WORD_W]);
    end

    for (genvar g = 0; g < NUM_PARTS; g++) begin : g_part
        logic [WORD_W-1:0] word_q;

        // A full load wins over a word write in the same cycle.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (load_en) begin
                word_q <= load_word[g];
            end else if (wr_en[g]) begin
                word_q <= wr_data;
            end
        end

        assign parts_q[g*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/prod_combine.sv
module prod_combine #(
    parameter  int WORD_W = 16,
    parameter  int HI_W   = 8,
    localparam int ACC_W  = 2*WORD_W + HI_W
) (
    input  logic [WORD_W-1:0] low_w,
    input  logic [WORD_W-1:0] mid_w,
    input  logic [WORD_W-1:0] mid2_w,
    input  logic [HI_W-1:0]   high_b,
    output logic [ACC_W-1:0]  prod_o
);

    logic [WORD_W:0]    mid_sum;
    logic [ACC_W-1:0]   lower_term;
    logic [ACC_W-1:0]   upper_term;

    always_comb begin
        // The middle words are added first; the extra bit carries above them.
        mid_sum    = {1'b0, mid_w} + {1'b0, mid2_w};
        // The shifted sum and the low word do not overlap, so OR is a concatenation.
        lower_term = ACC_W'({mid_sum, low_w});
        // Sign extension of the high byte adds nothing inside ACC_W bits.
        upper_term = {high_b, {(2*WORD_W){1'b0}}};
        prod_o     = upper_term + lower_term;
    end

endmodule

// File: rtl/prod_rounder.sv
module prod_rounder #(
    parameter  int WORD_W = 16,
    parameter  int HI_W   = 8,
    localparam int ACC_W  = 2*WORD_W + HI_W,
    localparam int KEEP_W = ACC_W - WORD_W
) (
    input  logic [ACC_W-1:0] val_i,
    output logic [ACC_W-1:0] rnd_o
);

    logic              half_set;
    logic              below_nz;
    logic              carry_up;
    logic [KEEP_W-1:0] kept;

    // Adding 2^(W-1) or 2^(W-1)-1 carries into bit W when the dropped bits
    // are at least one half, ties going up only when bit W is already 1.
    always_comb begin
        half_set = val_i[WORD_W-1];
        below_nz = |val_i[WORD_W-2:0];
        carry_up = half_set && (val_i[WORD_W] || below_nz);
        kept     = val_i[ACC_W-1:WORD_W] + KEEP_W'(carry_up);
        rnd_o    = {kept, {WORD_W{1'b0}}};
    end

endmodule

// File: rtl/prod_round_unit.sv
module prod_round_unit
    import prod_round_pkg::*;
#(
    parameter  int WORD_W  = 16,
    parameter  int HI_W    = 8,
    localparam int ACC_W   = 2*WORD_W + HI_W,
    localparam int PARTS_W = NUM_PARTS*WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PARTS-1:0] wr_en,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 load_en,
    input  logic [ACC_W-1:0]     load_val,
    input  logic [ACC_W-1:0]     acc_in,
    output logic [PARTS_W-1:0]   parts_q,
    output logic [ACC_W-1:0]     prod_out,
    output logic [ACC_W-1:0]     prod_rnd,
    output logic [ACC_W-1:0]     acc_rnd
);

    localparam int NUM_RND = 2;

    logic [ACC_W-1:0] rnd_src [NUM_RND];
    logic [ACC_W-1:0] rnd_dst [NUM_RND];

    prod_part_regs #(.WORD_W(WORD_W), .HI_W(HI_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .load_en  (load_en),
        .load_val (load_val),
        .parts_q  (parts_q)
    );

    prod_combine #(.WORD_W(WORD_W), .HI_W(HI_W)) u_comb (
        .low_w  (parts_q[int'(PART_LOW)*WORD_W  +: WORD_W]),
        .mid_w  (parts_q[int'(PART_MID)*WORD_W  +: WORD_W]),
        .mid2_w (parts_q[int'(PART_MID2)*WORD_W +: WORD_W]),
        .high_b (parts_q[int'(PART_HIGH)*WORD_W +: HI_W]),
        .prod_o (prod_out)
    );

    assign rnd_src[0] = prod_out;
    assign rnd_src[1] = acc_in;

    // One rounder per source; the product and the accumulator share the rule.
    for (genvar r = 0; r < NUM_RND; r++) begin : g_rnd
        prod_rounder #(.WORD_W(WORD_W), .HI_W(HI_W)) u_rnd (
            .val_i (rnd_src[r]),
            .rnd_o (rnd_dst[r])
        );
    end

    assign prod_rnd = rnd_dst[0];
    assign acc_rnd  = rnd_dst[1];

endmodule

// File: rtl/prod_round_chk.sv
module prod_round_chk
    import prod_round_pkg::*;
#(
    parameter  int WORD_W  = 16,
    parameter  int HI_W    = 8,
    localparam int ACC_W   = 2*WORD_W + HI_W,
    localparam int PARTS_W = NUM_PARTS*WORD_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PARTS-1:0] wr_en,
    input logic [WORD_W-1:0]    wr_data,
    input logic                 load_en,
    input logic [ACC_W-1:0]     load_val,
    input logic [ACC_W-1:0]     acc_in,
    input logic [PARTS_W-1:0]   parts_q,
    input logic [ACC_W-1:0]     prod_out,
    input logic [ACC_W-1:0]     prod_rnd,
    input logic [ACC_W-1:0]     acc_rnd
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (parts_q == '0));

    p_low_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[0] && !load_en) |=> (parts_q[WORD_W-1:0] == $past(wr_data)));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && wr_en == '0) |=> $stable(parts_q));

    p_load_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (parts_q == {{(WORD_W-HI_W){1'b0}}, $past(load_val[ACC_W-1:2*WORD_W]),
                                 {WORD_W{1'b0}}, $past(load_val[2*WORD_W-1:0])}));

    p_load_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && wr_en != '0) |=> (parts_q[2*WORD_W-1:0] == $past(load_val[2*WORD_W-1:0])));

    p_load_product_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (prod_out == $past(load_val)));

    p_round_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !prod_out[WORD_W-1] |-> (prod_rnd == {prod_out[ACC_W-1:WORD_W], {WORD_W{1'b0}}}));

    p_tie_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_in[WORD_W:0] == {2'b01, {(WORD_W-1){1'b0}}})
            |-> (acc_rnd == {acc_in[ACC_W-1:WORD_W], {WORD_W{1'b0}}}));

    p_tie_odd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_in[WORD_W:0] == {2'b11, {(WORD_W-1){1'b0}}})
            |-> (acc_rnd[ACC_W-1:WORD_W] == acc_in[ACC_W-1:WORD_W] + 1'b1));

endmodule

bind prod_round_unit prod_round_chk #(.WORD_W(WORD_W), .HI_W(HI_W)) u_chk (.*);

// File: tb/prod_round_unit_tb.sv
module prod_round_unit_tb;

    localparam int W   = 4;
    localparam int HI  = 2;
    localparam int ACC = 2*W + HI;
    localparam longint MASK = (longint'(1) << ACC) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       wr_en = '0;
    logic [W-1:0]     wr_data = '0;
    logic             load_en = 1'b0;
    logic [ACC-1:0]   load_val = '0;
    logic [ACC-1:0]   acc_in = '0;
    logic [4*W-1:0]   parts_q;
    logic [ACC-1:0]   prod_out;
    logic [ACC-1:0]   prod_rnd;
    logic [ACC-1:0]   acc_rnd;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prod_round_unit #(.WORD_W(W), .HI_W(HI)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .load_en(load_en), .load_val(load_val), .acc_in(acc_in),
        .parts_q(parts_q), .prod_out(prod_out), .prod_rnd(prod_rnd), .acc_rnd(acc_rnd)
    );

    function automatic longint exp_prod(int lo, int mi, int m2, int hi);
        longint hb = longint'(hi % (1 << HI));
        if (hb >= (1 << (HI-1))) hb = hb - (1 << HI);
        return (hb * (longint'(1) << (2*W)) + ((longint'(mi + m2) << W) | longint'(lo))) & MASK;
    endfunction

    function automatic longint exp_round(longint v);
        longint r;
        if (((v >> W) & 1) != 0) r = v + (longint'(1) << (W-1));
        else                     r = v + (longint'(1) << (W-1)) - 1;
        r = r & ~((longint'(1) << W) - 1);
        return r & MASK;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            if (n_errors <= 20)
                $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Entered at a falling edge; leaves at the next one, after the write took effect.
    task automatic wr_part(int idx, int d);
        wr_en   = 4'(1 << idx);
        wr_data = W'(d);
        @(negedge clk);
        wr_en   = '0;
    endtask

    task automatic do_load(int v, logic [3:0] we, int d);
        load_en  = 1'b1;
        load_val = ACC'(v);
        wr_en    = we;
        wr_data  = W'(d);
        @(negedge clk);
        load_en  = 1'b0;
        wr_en    = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset and right after release
        chk("R1 parts in reset", longint'(parts_q), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 parts after reset", longint'(parts_q), 0);
        chk("R1 product after reset", longint'(prod_out), 0);
        chk("R1 rounded after reset", longint'(prod_rnd), 0);
        chk("R1 acc rounded after reset", longint'(acc_rnd), 0);

        // R2 R5 R6 R7 R9: every combination of the four parts
        for (int lo = 0; lo < 16; lo++) begin
            wr_part(0, lo);
            for (int hi = 0; hi < 16; hi++) begin
                wr_part(3, hi);
                for (int m2 = 0; m2 < 16; m2++) begin
                    wr_part(2, m2);
                    for (int mi = 0; mi < 16; mi++) begin
                        wr_part(1, mi);
                        if (mi == 15)
                            chk("R2 parts after word writes", longint'(parts_q),
                                longint'((hi << 12) | (m2 << 8) | (mi << 4) | lo));
                        chk("R5 R6 R9 combined product", longint'(prod_out),
                            exp_prod(lo, mi, m2, hi));
                        chk("R7 R9 rounded product", longint'(prod_rnd),
                            exp_round(exp_prod(lo, mi, m2, hi)));
                    end
                end
            end
        end

        // R3 R5: every load value alone; R4: every load value against writes to all parts
        for (int v = 0; v < (1 << ACC); v++) begin
            do_load(v, 4'b0000, 0);
            chk("R3 load fields", longint'(parts_q),
                longint'(((v >> 8) << 12) | (v & 8'hFF)));
            chk("R5 load product", longint'(prod_out), longint'(v));
            do_load(v, 4'b1111, (v & 15) ^ 4'hA);
            chk("R4 load beats writes", longint'(parts_q),
                longint'(((v >> 8) << 12) | (v & 8'hFF)));
        end

        // R8 R9: every accumulator value, rounded combinationally
        for (int a = 0; a < (1 << ACC); a++) begin
            acc_in = ACC'(a);
            #1;
            chk("R8 R9 accumulator rounding", longint'(acc_rnd), exp_round(longint'(a)));
            @(negedge clk);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule